// File: doc/BRIEF.md
# Vector branch condition reducer

This block decides whether a vectorised conditional branch is taken. It walks a vector of 4-bit condition fields one element per clock. For each element it picks one bit of the field, compares that bit with an expected value, and folds the result into a single branch verdict.

Two reductions are available. The any-mode takes the branch as soon as one element test succeeds. The all-mode takes the branch only when no element test fails. An invert control flips the expected bit, so the negated forms (all-fail, any-fail) reuse the same reduction path. Evaluation stops on the first element whose result fixes the outcome. Each element can be masked by a predicate bit. A masked element is either left out of the reduction or, when zeroing is enabled, given a fixed substitute result without its field being examined.

A start strobe captures the vector length and all control fields. A single-cycle done strobe then reports the verdict and the index of the element where evaluation stopped. A start that arrives while an evaluation is running is ignored.

Top module: `vbr_reducer`

## Requirements
- R1: In any-mode (all_mode=0) the branch is taken at the first element whose test succeeds, and stop_idx reports that element.
- R2: In all-mode (all_mode=1) the first element whose test fails ends evaluation with taken=0, and stop_idx reports that element.
- R3: The test of element i compares cr_fields[i*4+bit_sel] with want_bit XOR invert. Setting invert=1 gives the negated reductions through the same path.
- R4: Evaluation exits early. When the stopping element is k (vec_len>0), done goes high on the (k+2)-th rising edge, where the edge that captures start counts as the first.
- R5: With zero_en=0, an element whose pred_mask bit is 0 is skipped. It never ends evaluation and does not change the verdict.
- R6: With zero_en=1, an element whose pred_mask bit is 0 takes subst_val as its test result, whatever its condition field holds.
- R7: When no element decides the outcome, taken is 0 in any-mode and 1 in all-mode, and stop_idx is vec_len-1. This also covers the case where every element is skipped.
- R8: With vec_len=0, done is registered on the edge that captures start. taken follows the R7 default and stop_idx is 0.
- R9: After reset, done, taken and stop_idx are 0. done is high for exactly one cycle per accepted start.
- R10: A start that arrives before the running evaluation has raised done is ignored. It does not change that result and it does not queue a second run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an evaluation (accepted only when idle) |
| vec_len | input | 7 | Number of elements, 0 to 64 |
| cr_fields | input | 256 | Condition fields; field i occupies bits i*4+3..i*4 |
| bit_sel | input | 2 | Bit of each field under test |
| want_bit | input | 1 | Expected value of the selected bit |
| invert | input | 1 | Flips want_bit for the negated reductions |
| all_mode | input | 1 | 0 = any-mode, 1 = all-mode |
| pred_mask | input | 64 | Predicate bit per element, 1 = active |
| zero_en | input | 1 | 1 = masked elements use subst_val, 0 = masked elements are skipped |
| subst_val | input | 1 | Test result forced onto masked elements when zero_en=1 |
| done | output | 1 | One-cycle completion strobe |
| taken | output | 1 | Branch verdict, valid with done |
| stop_idx | output | 6 | Index of the last element evaluated, valid with done |

## Verification
The assertions take two things for granted about the inputs. First, vec_len never exceeds the element count of the vector. Second, in the live-read variant, the condition fields stay steady for the whole run. The bench drives every run with vec_len between 0 and 64 and holds all data inputs unchanged from start to done. It changes only start and the control fields during the overlap test, so the run-length and index properties see legal inputs throughout.

// File: rtl/vbr_pkg.sv
package vbr_pkg;

   // reduction flavour; negated flavours come from flipping the expected bit
   typedef enum logic {
      RED_ANY = 1'b0,
      RED_ALL = 1'b1
   } red_mode_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } seq_state_e;

   // per-element outcome: counts=0 means the element is left out
   typedef struct packed {
      logic counts;
      logic pass;
   } elem_res_t;

   // verdict when no element settles the outcome
   function automatic logic fallback_taken(input red_mode_e m);
      return (m == RED_ALL);
   endfunction

endpackage

// File: rtl/vbr_elem_eval.sv
module vbr_elem_eval
   import vbr_pkg::*;
#(
   parameter  int unsigned FIELD_W = 4,
   localparam int unsigned SEL_W   = $clog2(FIELD_W)
) (
   input  logic [FIELD_W-1:0] field,
   input  logic [SEL_W-1:0]   sel,
   input  logic               want,
   input  logic               pred,
   input  logic               zero_en,
   input  logic               subst,
   output elem_res_t          res
);

   // masked + zeroing: the field is not consulted, substitute decides
   always_comb begin
      res.counts = pred | zero_en;
      res.pass   = pred ? (field[sel] == want) : subst;
   end

endmodule

// File: rtl/vbr_step.sv
module vbr_step
   import vbr_pkg::*;
(
   input  elem_res_t res,
   input  red_mode_e mode,
   output logic      decided,
   output logic      verdict
);

   // any-mode settles on a pass, all-mode settles on a fail
   assign decided = res.counts && (res.pass != (mode == RED_ALL));
   assign verdict = res.pass;

endmodule

// File: rtl/vbr_seq.sv
module vbr_seq
   import vbr_pkg::*;
#(
   parameter  int unsigned NUM_ELEM = 64,
   localparam int unsigned LEN_W    = $clog2(NUM_ELEM + 1),
   localparam int unsigned IDX_W    = $clog2(NUM_ELEM)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] vec_len,
   input  red_mode_e        mode_in,
   input  logic             decided,
   input  logic             verdict,
   output logic             busy,
   output logic             accept,
   output logic [IDX_W-1:0] cnt,
   output red_mode_e        mode_q,
   output logic             last,
   output logic             done,
   output logic             taken,
   output logic [IDX_W-1:0] stop_idx
);

   seq_state_e       state_q;
   logic [LEN_W-1:0] vl_q;

   assign busy   = (state_q == ST_RUN);
   assign accept = (state_q == ST_IDLE) && start;
   assign last   = busy && ((LEN_W'(cnt) + LEN_W'(1)) == vl_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         vl_q     <= '0;
         cnt      <= '0;
         mode_q   <= RED_ANY;
         done     <= 1'b0;
         taken    <= 1'b0;
         stop_idx <= '0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  vl_q   <= vec_len;
                  mode_q <= mode_in;
                  cnt    <= '0;
                  if (vec_len == '0) begin
                     done     <= 1'b1;
                     taken    <= fallback_taken(mode_in);
                     stop_idx <= '0;
                  end else begin
                     state_q <= ST_RUN;
                  end
               end
            end
            ST_RUN: begin
               if (decided || last) begin
                  done     <= 1'b1;
                  taken    <= decided ? verdict : fallback_taken(mode_q);
                  stop_idx <= cnt;
                  state_q  <= ST_IDLE;
               end else begin
                  cnt <= cnt + IDX_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R9: completion strobe lasts a single cycle
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: a start during a run leaves the captured length untouched
   a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(vl_q));

   // R4: the walk never steps past the captured length
   a_r4_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (LEN_W'(cnt) < vl_q));

   // R7: reported index stays inside the vector
   a_r7_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (vl_q != '0)) |-> (LEN_W'(stop_idx) < vl_q));

   // input assumption: length fits the vector
   a_r8_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (vec_len <= LEN_W'(NUM_ELEM)));

endmodule

// File: rtl/vbr_reducer.sv
module vbr_reducer
   import vbr_pkg::*;
#(
   parameter  int unsigned NUM_ELEM   = 64,
   parameter  int unsigned FIELD_W    = 4,
   parameter  bit          CAPTURE_CR = 1'b1,
   localparam int unsigned LEN_W      = $clog2(NUM_ELEM + 1),
   localparam int unsigned IDX_W      = $clog2(NUM_ELEM),
   localparam int unsigned SEL_W      = $clog2(FIELD_W),
   localparam int unsigned CR_W       = NUM_ELEM * FIELD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] vec_len,
   input  logic [CR_W-1:0]  cr_fields,
   input  logic [SEL_W-1:0] bit_sel,
   input  logic             want_bit,
   input  logic             invert,
   input  logic             all_mode,
   input  logic [NUM_ELEM-1:0] pred_mask,
   input  logic             zero_en,
   input  logic             subst_val,
   output logic             done,
   output logic             taken,
   output logic [IDX_W-1:0] stop_idx
);

   // elaboration-time parameter checks
   if (NUM_ELEM < 2) begin : g_chk_elem
      $error("NUM_ELEM must be at least 2");
   end
   if ((FIELD_W < 2) || ((FIELD_W & (FIELD_W - 1)) != 0)) begin : g_chk_field
      $error("FIELD_W must be a power of two, at least 2");
   end

   logic             busy;
   logic             accept;
   logic             last;
   logic [IDX_W-1:0] cnt;
   red_mode_e        mode_q;
   logic             decided;
   logic             verdict;
   elem_res_t        res;

   logic [SEL_W-1:0]    sel_q;
   logic                want_q;
   logic                zen_q;
   logic                subst_q;
   logic [NUM_ELEM-1:0] mask_q;
   logic [CR_W-1:0]     cr_src;

   // control capture on an accepted start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= '0;
         want_q  <= 1'b0;
         zen_q   <= 1'b0;
         subst_q <= 1'b0;
         mask_q  <= '0;
      end else if (accept) begin
         sel_q   <= bit_sel;
         want_q  <= want_bit ^ invert;
         zen_q   <= zero_en;
         subst_q <= subst_val;
         mask_q  <= pred_mask;
      end
   end

   // condition source: snapshot at start, or read live each cycle
   if (CAPTURE_CR) begin : g_cap
      logic [CR_W-1:0] cr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cr_q <= '0;
         else if (accept) cr_q <= cr_fields;
      end
      assign cr_src = cr_q;
   end else begin : g_live
      assign cr_src = cr_fields;
   end

   logic [FIELD_W-1:0] cur_field;
   logic               cur_pred;
   assign cur_field = cr_src[cnt*FIELD_W +: FIELD_W];
   assign cur_pred  = mask_q[cnt];

   vbr_elem_eval #(.FIELD_W(FIELD_W)) u_eval (
      .field   (cur_field),
      .sel     (sel_q),
      .want    (want_q),
      .pred    (cur_pred),
      .zero_en (zen_q),
      .subst   (subst_q),
      .res     (res)
   );

   vbr_step u_step (
      .res     (res),
      .mode    (mode_q),
      .decided (decided),
      .verdict (verdict)
   );

   vbr_seq #(.NUM_ELEM(NUM_ELEM)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .vec_len  (vec_len),
      .mode_in  (all_mode ? RED_ALL : RED_ANY),
      .decided  (decided),
      .verdict  (verdict),
      .busy     (busy),
      .accept   (accept),
      .cnt      (cnt),
      .mode_q   (mode_q),
      .last     (last),
      .done     (done),
      .taken    (taken),
      .stop_idx (stop_idx)
   );

   // R5: a skipped element that is not the last one never finishes the run
   a_r5_skip_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !res.counts && !last) |=> !done);

   // R1: an any-mode pass finishes the run with the branch taken
   a_r1_any_pass_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (mode_q == RED_ANY) && res.counts && res.pass) |=> (done && taken));

   // R2: an all-mode failure finishes the run with the branch not taken
   a_r2_all_fail_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (mode_q == RED_ALL) && res.counts && !res.pass) |=> (done && !taken));

   // R6: zeroed element result equals the substitute value
   a_r6_subst_used: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && zen_q && !cur_pred) |-> (res.counts && (res.pass == subst_q)));

endmodule

// File: tb/vbr_reducer_test.sv
module vbr_reducer_test;

   localparam time CLK_PERIOD = 10ns;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [6:0]   vec_len = '0;
   logic [255:0] cr_fields = '0;
   logic [1:0]   bit_sel = '0;
   logic         want_bit = 1'b0;
   logic         invert = 1'b0;
   logic         all_mode = 1'b0;
   logic [63:0]  pred_mask = '0;
   logic         zero_en = 1'b0;
   logic         subst_val = 1'b0;
   logic         done;
   logic         taken;
   logic [5:0]   stop_idx;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   vbr_reducer uut (
      .clk(clk), .rst_n(rst_n), .start(start), .vec_len(vec_len),
      .cr_fields(cr_fields), .bit_sel(bit_sel), .want_bit(want_bit),
      .invert(invert), .all_mode(all_mode), .pred_mask(pred_mask),
      .zero_en(zero_en), .subst_val(subst_val), .done(done),
      .taken(taken), .stop_idx(stop_idx)
   );

   typedef struct packed {
      logic [3:0]  rq;
      logic [6:0]  vl;
      logic [1:0]  sel;
      logic        want;
      logic        inv;
      logic        all;
      logic        zen;
      logic        subst;
      logic [63:0] pat;
      logic [63:0] mask;
      logic        etaken;
      logic [5:0]  eidx;
   } vec_t;

   localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

   // pat bit i = value of the selected bit of field i; other bits get its complement
   localparam vec_t VECS [17] = '{
      '{4'd1,  7'd8,  2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 64'h10, ONES, 1'b1, 6'd4},   // R1 first pass
      '{4'd7,  7'd8,  2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0,  ONES, 1'b0, 6'd7},   // R7 any default
      '{4'd7,  7'd8,  2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 64'hFF, ONES, 1'b1, 6'd7},   // R7 all default
      '{4'd2,  7'd8,  2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 64'hF7, ONES, 1'b0, 6'd3},   // R2 first fail
      '{4'd3,  7'd5,  2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 64'h0,  ONES, 1'b1, 6'd4},   // R3 inverted all
      '{4'd3,  7'd64, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFD, ONES, 1'b1, 6'd1}, // R3 inverted any
      '{4'd5,  7'd8,  2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 64'h04, 64'hFFFF_FFFF_FFFF_FFFB, 1'b0, 6'd7}, // R5 skip pass
      '{4'd6,  7'd8,  2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 64'h0,  64'hFFFF_FFFF_FFFF_FFFB, 1'b1, 6'd2}, // R6 subst 1
      '{4'd6,  7'd8,  2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 64'hFF, 64'hFFFF_FFFF_FFFF_FFDF, 1'b0, 6'd5}, // R6 subst 0
      '{4'd5,  7'd8,  2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 64'hFF, 64'hFFFF_FFFF_FFFF_FFDF, 1'b1, 6'd7}, // R5 skip fail
      '{4'd7,  7'd6,  2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0,  64'h0, 1'b1, 6'd5},  // R7 all skipped
      '{4'd7,  7'd64, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0,  64'h0, 1'b0, 6'd63}, // R7 any skipped
      '{4'd1,  7'd64, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 64'h8000_0000_0000_0000, ONES, 1'b1, 6'd63}, // R1 last
      '{4'd2,  7'd1,  2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0,  ONES, 1'b0, 6'd0},   // R2 single
      '{4'd8,  7'd0,  2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0,  ONES, 1'b0, 6'd0},   // R8 any empty
      '{4'd8,  7'd0,  2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0,  ONES, 1'b1, 6'd0},   // R8 all empty
      '{4'd6,  7'd4,  2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 64'h4,  64'hFFFF_FFFF_FFFF_FFFB, 1'b0, 6'd3}  // R6 field ignored
   };

   function automatic logic [255:0] mk_cr(input logic [63:0] pat, input logic [1:0] sel);
      logic [255:0] r;
      for (int i = 0; i < 64; i++)
         for (int b = 0; b < 4; b++)
            r[i*4+b] = (b == int'(sel)) ? pat[i] : ~pat[i];
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic load(input vec_t v);
      vec_len   = v.vl;
      bit_sel   = v.sel;
      want_bit  = v.want;
      invert    = v.inv;
      all_mode  = v.all;
      zero_en   = v.zen;
      subst_val = v.subst;
      pred_mask = v.mask;
      cr_fields = mk_cr(v.pat, v.sel);
   endtask

   // called at a falling edge; returns at a falling edge
   task automatic apply(input vec_t v);
      int    lat;
      string tag;
      tag = $sformatf("R%0d", v.rq);
      load(v);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 200) begin
         @(negedge clk);
         lat++;
      end
      chk(done === 1'b1, tag, "done seen", longint'(done), 1);
      chk(taken === v.etaken, tag, "taken", longint'(taken), longint'(v.etaken));
      chk(stop_idx === v.eidx, tag, "stop_idx", longint'(stop_idx), longint'(v.eidx));
      // R4 early-exit latency
      chk(lat == ((v.vl == 0) ? 1 : int'(v.eidx) + 2), "R4", "latency",
          longint'(lat), longint'((v.vl == 0) ? 1 : int'(v.eidx) + 2));
      @(negedge clk);
      chk(done === 1'b0, "R9", "done width", longint'(done), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(done === 1'b0, "R9", "reset done", longint'(done), 0);
      chk(taken === 1'b0, "R9", "reset taken", longint'(taken), 0);
      chk(stop_idx === 6'd0, "R9", "reset stop_idx", longint'(stop_idx), 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int k = 0; k < 17; k++) apply(VECS[k]);

      // R10: second start during a long any-mode run that never passes
      begin
         vec_t a;
         vec_t b;
         int   lat;
         a = '{4'd10, 7'd64, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0, ONES, 1'b0, 6'd63};
         b = '{4'd10, 7'd1,  2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0, ONES, 1'b1, 6'd0};
         load(a);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         lat = 1;
         repeat (3) begin @(negedge clk); lat++; end
         vec_len  = b.vl;
         all_mode = b.all;
         start    = 1'b1;
         @(negedge clk);
         lat++;
         start = 1'b0;
         while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
         end
         chk(taken === 1'b0, "R10", "taken", longint'(taken), 0);
         chk(stop_idx === 6'd63, "R10", "stop_idx", longint'(stop_idx), 63);
         chk(lat == 65, "R10", "latency", longint'(lat), 65);
         for (int w = 0; w < 5; w++) begin
            @(negedge clk);
            chk(done === 1'b0, "R10", "no queued run", longint'(done), 0);
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule